// File: doc/BRIEF.md
# Protected Configuration Store

This block keeps the configuration pattern of a programmable device, an eight-byte user signature and one protection bit. A host drives commands over a valid/ready port. Each command has an opcode, an address and a data byte. The block answers each completed command with a one-cycle completion strobe, an error flag and a data byte. A separate register bank can be loaded directly with a chosen state, which puts the device's state registers into a known condition for test.

Once the protection bit is set, the configuration words can no longer be read back and the register bank can no longer be loaded. The signature bytes stay fully readable and writable. The protection bit takes effect on the very next command. The only way to clear it is the wipe command, which also returns every configuration word and signature byte to the blank value 0xFF. The wipe walks the configuration words one per cycle, and the port reports busy for the whole walk.

Top module: `cfgsec_store`

## Requirements
- R1: Opcode 0 writes `cmd_wdata` to configuration word `cmd_addr`. Opcode 1 reads that word back. Every accepted command other than opcode 6 raises `rsp_done` for exactly the one cycle after acceptance. Read data appears on `rsp_rdata` in that same cycle, and `rsp_rdata` is 0 for commands that return no data.
- R2: The signature has eight bytes, selected by `cmd_addr[2:0]`. Opcode 2 writes a byte and opcode 3 reads it.
- R3: Opcode 4 sets the protection bit, which is seen on `sec_locked`. The command accepted in the very next cycle already sees the bit set. No opcode except 6 clears it.
- R4: While protected, opcode 1 completes with `rsp_err`=1 and `rsp_rdata`=0.
- R5: Opcode 5 loads `cmd_wdata` into `preg_q` when not protected, with `rsp_err`=0. While protected it completes with `rsp_err`=1 and leaves `preg_q` unchanged.
- R6: Signature reads and writes behave the same whether or not the block is protected, and they never set `rsp_err`.
- R7: Opcode 6 clears the protection bit at once. It then holds `cmd_ready` low for DEPTH cycles and raises `rsp_done` in the cycle `cmd_ready` returns. After that, every configuration word and signature byte reads 0xFF and `preg_q` keeps its value.
- R8: After reset, `cmd_ready`=1, `rsp_done`=0, `rsp_err`=0, `sec_locked`=0 and `preg_q`=0, and configuration words read 0xFF.
- R9: Opcode 7 is reserved. It completes with `rsp_err`=1 and `rsp_rdata`=0, and changes neither `preg_q` nor `sec_locked`.
- R10: A command presented while `cmd_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Opcode (0..7, see requirements) |
| cmd_addr | input | AW (4) | Configuration word index; low 3 bits select a signature byte |
| cmd_wdata | input | DW (8) | Write or load data |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Command refused or reserved |
| rsp_rdata | output | DW (8) | Read result |
| sec_locked | output | 1 | Protection bit |
| preg_q | output | DW (8) | Loadable register bank |

## Verification
The assertions assume that reset is applied before the first command and that `cmd_op`, `cmd_addr` and `cmd_wdata` are steady at the edge where a command is accepted. The properties that look one cycle back rely on that. The stimulus changes inputs only on the falling clock edge and holds reset for several cycles at the start. It presents a stray command during a wipe on purpose, and it drops that command before `cmd_ready` returns, so no accepted command has a changing opcode.

// File: rtl/cfgsec_pkg.sv
package cfgsec_pkg;

    typedef enum logic [2:0] {
        OP_CFG_WR  = 3'd0,
        OP_CFG_RD  = 3'd1,
        OP_SIG_WR  = 3'd2,
        OP_SIG_RD  = 3'd3,
        OP_LOCK    = 3'd4,
        OP_PRELOAD = 3'd5,
        OP_WIPE    = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WIPE = 1'b1
    } st_e;

    // strobes raised by the controller in the cycle a command is taken
    typedef struct packed {
        logic cfg_we;
        logic sig_we;
        logic pre_we;
        logic wipe;
    } act_t;

    localparam int SIG_BYTES = 8;
    localparam int SIG_IW    = $clog2(SIG_BYTES);
    localparam int SIG_W     = 8;

    // commands refused once protection is active
    function automatic logic op_guarded(op_e op);
        return (op == OP_CFG_RD) || (op == OP_PRELOAD);
    endfunction

endpackage

// File: rtl/cfgsec_cfg_mem.sv
module cfgsec_cfg_mem
    import cfgsec_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cfgsec_sig_mem.sv
module cfgsec_sig_mem
    import cfgsec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [SIG_IW-1:0] idx,
    input  logic [SIG_W-1:0]  wdata,
    output logic [SIG_W-1:0]  rdata
);

    logic [SIG_BYTES*SIG_W-1:0] flat;

    for (genvar g = 0; g < SIG_BYTES; g++) begin : g_byte
        logic [SIG_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                q <= '1;
            end else if (we && (idx == SIG_IW'(g))) begin
                q <= wdata;
            end
        end
        assign flat[g*SIG_W +: SIG_W] = q;
    end

    assign rdata = flat[idx*SIG_W +: SIG_W];

endmodule

// File: rtl/cfgsec_ctrl.sv
module cfgsec_ctrl
    import cfgsec_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [DW-1:0]    cmd_wdata,
    input  logic [DW-1:0]    cfg_rdata,
    input  logic [SIG_W-1:0] sig_rdata,
    output act_t             act,
    output logic             cfg_we,
    output logic [AW-1:0]    cfg_waddr,
    output logic [DW-1:0]    cfg_wdata,
    output logic             lock_q,
    output logic             rsp_done,
    output logic             rsp_err,
    output logic [DW-1:0]    rsp_rdata
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    st_e           st;
    logic [AW-1:0] wipe_idx;
    op_e           op;
    logic          acc;

    assign op        = op_e'(cmd_op);
    assign cmd_ready = (st == ST_IDLE);
    assign acc       = cmd_valid && cmd_ready;

    always_comb begin
        act = '0;
        if (acc) begin
            case (op)
                OP_CFG_WR:  act.cfg_we = 1'b1;
                OP_SIG_WR:  act.sig_we = 1'b1;
                OP_PRELOAD: act.pre_we = !lock_q;
                OP_WIPE:    act.wipe   = 1'b1;
                default:    ;
            endcase
        end
    end

    // the wipe walk owns the write port while the command port is closed
    assign cfg_we    = act.cfg_we || (st == ST_WIPE);
    assign cfg_waddr = (st == ST_WIPE) ? wipe_idx : cmd_addr;
    assign cfg_wdata = (st == ST_WIPE) ? '1 : cmd_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            wipe_idx  <= '0;
            lock_q    <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            case (st)
                ST_IDLE: begin
                    if (acc) begin
                        if (op == OP_WIPE) begin
                            st       <= ST_WIPE;
                            wipe_idx <= '0;
                            lock_q   <= 1'b0;
                        end else begin
                            rsp_done <= 1'b1;
                            if (op_guarded(op) && lock_q) begin
                                rsp_err <= 1'b1;
                            end else begin
                                case (op)
                                    OP_CFG_RD: rsp_rdata <= cfg_rdata;
                                    OP_SIG_RD: rsp_rdata <= DW'(sig_rdata);
                                    OP_LOCK:   lock_q    <= 1'b1;
                                    OP_RSVD:   rsp_err   <= 1'b1;
                                    default:   ;
                                endcase
                            end
                        end
                    end
                end
                ST_WIPE: begin
                    wipe_idx <= wipe_idx + 1'b1;
                    if (wipe_idx == LAST) begin
                        st       <= ST_IDLE;
                        rsp_done <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgsec_store.sv
module cfgsec_store
    import cfgsec_pkg::*;
#(
    parameter  int DW    = 8,
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic [DW-1:0] rsp_rdata,
    output logic          sec_locked,
    output logic [DW-1:0] preg_q
);

    act_t             act;
    logic             cfg_we;
    logic [AW-1:0]    cfg_waddr;
    logic [DW-1:0]    cfg_wdata;
    logic [DW-1:0]    cfg_rdata;
    logic [SIG_W-1:0] sig_rdata;

    cfgsec_ctrl #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cfg_rdata (cfg_rdata),
        .sig_rdata (sig_rdata),
        .act       (act),
        .cfg_we    (cfg_we),
        .cfg_waddr (cfg_waddr),
        .cfg_wdata (cfg_wdata),
        .lock_q    (sec_locked),
        .rsp_done  (rsp_done),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    cfgsec_cfg_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .waddr (cfg_waddr),
        .wdata (cfg_wdata),
        .raddr (cmd_addr),
        .rdata (cfg_rdata)
    );

    cfgsec_sig_mem u_sig (
        .clk   (clk),
        .rst   (rst),
        .clr   (act.wipe),
        .we    (act.sig_we),
        .idx   (cmd_addr[SIG_IW-1:0]),
        .wdata (cmd_wdata[SIG_W-1:0]),
        .rdata (sig_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            preg_q <= '0;
        end else if (act.pre_we) begin
            preg_q <= cmd_wdata;
        end
    end

endmodule

// File: rtl/cfgsec_store_chk.sv
module cfgsec_store_chk
    import cfgsec_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [2:0]    cmd_op,
    input logic [DW-1:0] cmd_wdata,
    input logic          rsp_done,
    input logic          rsp_err,
    input logic [DW-1:0] rsp_rdata,
    input logic          sec_locked,
    input logic [DW-1:0] preg_q
);

    logic acc;
    assign acc = cmd_valid && cmd_ready;

    AST_DONE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op != OP_WIPE) |=> rsp_done);                              // R1

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sec_locked && !(acc && cmd_op == OP_WIPE)) |=> sec_locked);           // R3

    AST_LOCK_SETS: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_LOCK) |=> sec_locked);                            // R3

    AST_GUARD_READ: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_CFG_RD && sec_locked) |=> (rsp_err && rsp_rdata == '0)); // R4

    AST_GUARD_LOAD: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_PRELOAD && sec_locked) |=> (rsp_err && $stable(preg_q))); // R5

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_PRELOAD && !sec_locked) |=> (preg_q == $past(cmd_wdata))); // R5

    AST_SIG_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (acc && (cmd_op == OP_SIG_RD || cmd_op == OP_SIG_WR)) |=> !rsp_err);    // R6

    AST_WIPE_OPENS: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_WIPE) |=> (!sec_locked && !cmd_ready && !rsp_done)); // R7

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |-> !rsp_done);                                             // R7

    AST_RSVD_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_RSVD) |=> (rsp_err && rsp_rdata == '0
                                        && $stable(preg_q) && $stable(sec_locked))); // R9

endmodule

bind cfgsec_store cfgsec_store_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_wdata  (cmd_wdata),
    .rsp_done   (rsp_done),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .sec_locked (sec_locked),
    .preg_q     (preg_q)
);

// File: tb/cfgsec_store_test.sv
module cfgsec_store_test;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [2:0] cmd_op = 3'd0;
    logic [3:0] cmd_addr = 4'd0;
    logic [7:0] cmd_wdata = 8'd0;
    logic       rsp_done;
    logic       rsp_err;
    logic [7:0] rsp_rdata;
    logic       sec_locked;
    logic [7:0] preg_q;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cfgsec_store #(.DW(8), .DEPTH(DEPTH)) uut (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .rsp_done   (rsp_done),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata),
        .sec_locked (sec_locked),
        .preg_q     (preg_q)
    );

    // {op, addr, wdata, exp_err, exp_lock, exp_rdata, exp_preg}
    localparam int NV = 17;
    localparam logic [32:0] VEC [NV] = '{
        {3'd0, 4'h3, 8'hA5, 1'b0, 1'b0, 8'h00, 8'h00},
        {3'd0, 4'hF, 8'h3C, 1'b0, 1'b0, 8'h00, 8'h00},
        {3'd1, 4'h3, 8'h00, 1'b0, 1'b0, 8'hA5, 8'h00},
        {3'd1, 4'hF, 8'h00, 1'b0, 1'b0, 8'h3C, 8'h00},
        {3'd1, 4'h7, 8'h00, 1'b0, 1'b0, 8'hFF, 8'h00},
        {3'd2, 4'h0, 8'h11, 1'b0, 1'b0, 8'h00, 8'h00},
        {3'd2, 4'h7, 8'h77, 1'b0, 1'b0, 8'h00, 8'h00},
        {3'd3, 4'h0, 8'h00, 1'b0, 1'b0, 8'h11, 8'h00},
        {3'd3, 4'hF, 8'h00, 1'b0, 1'b0, 8'h77, 8'h00},
        {3'd5, 4'h0, 8'h5A, 1'b0, 1'b0, 8'h00, 8'h5A},
        {3'd7, 4'h0, 8'hEE, 1'b1, 1'b0, 8'h00, 8'h5A},
        {3'd4, 4'h0, 8'h00, 1'b0, 1'b1, 8'h00, 8'h5A},
        {3'd1, 4'h3, 8'h00, 1'b1, 1'b1, 8'h00, 8'h5A},
        {3'd5, 4'h0, 8'hC3, 1'b1, 1'b1, 8'h00, 8'h5A},
        {3'd3, 4'h0, 8'h00, 1'b0, 1'b1, 8'h11, 8'h5A},
        {3'd2, 4'h1, 8'h22, 1'b0, 1'b1, 8'h00, 8'h5A},
        {3'd3, 4'h1, 8'h00, 1'b0, 1'b1, 8'h22, 8'h5A}
    };

    function automatic string tag_of(logic [2:0] op, logic lk);
        case (op)
            3'd0:    return "R1";
            3'd1:    return lk ? "R4" : "R1";
            3'd2,
            3'd3:    return lk ? "R6" : "R2";
            3'd4:    return "R3";
            3'd5:    return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic issue(logic [2:0] op, logic [3:0] addr, logic [7:0] wd);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        cmd_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int lowcnt;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 reset state
        chk("R8", "ready", 8'(cmd_ready), 8'h01);
        chk("R8", "done", 8'(rsp_done), 8'h00);
        chk("R8", "err", 8'(rsp_err), 8'h00);
        chk("R8", "locked", 8'(sec_locked), 8'h00);
        chk("R8", "preg", preg_q, 8'h00);
        issue(3'd1, 4'h0, 8'h00);
        chk("R8", "blank word", rsp_rdata, 8'hFF);

        // vector walk, back-to-back commands (entry 11 -> 12 covers R3 next-command lock)
        for (int i = 0; i < NV; i++) begin
            logic [32:0] v;
            string       t;
            v = VEC[i];
            issue(v[32:30], v[29:26], v[25:18]);
            t = tag_of(v[32:30], v[16]);
            chk(t, "done", 8'(rsp_done), 8'h01);
            chk(t, "err", 8'(rsp_err), 8'(v[17]));
            chk(t, "lock", 8'(sec_locked), 8'(v[16]));
            chk(t, "rdata", rsp_rdata, v[15:8]);
            chk(t, "preg", preg_q, v[7:0]);
        end

        // R1 completion strobe lasts one cycle
        @(negedge clk);
        chk("R1", "done after idle", 8'(rsp_done), 8'h00);

        // R7 wipe, with a stray command while busy (R10)
        issue(3'd6, 4'h0, 8'h00);
        chk("R7", "lock cleared", 8'(sec_locked), 8'h00);
        lowcnt = 0;
        for (int i = 0; i < 100 && !cmd_ready; i++) begin
            lowcnt++;
            if (i == 2) begin
                cmd_valid = 1'b1;
                cmd_op    = 3'd2;
                cmd_addr  = 4'h2;
                cmd_wdata = 8'h42;
            end
            if (i == 4) cmd_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
        chk("R7", "busy cycles", 8'(lowcnt), 8'(DEPTH));
        chk("R7", "done at end", 8'(rsp_done), 8'h01);
        chk("R7", "preg kept", preg_q, 8'h5A);

        issue(3'd1, 4'h3, 8'h00);
        chk("R7", "word blank", rsp_rdata, 8'hFF);
        chk("R7", "read allowed", 8'(rsp_err), 8'h00);
        issue(3'd3, 4'h0, 8'h00);
        chk("R7", "sig blank", rsp_rdata, 8'hFF);
        issue(3'd3, 4'h2, 8'h00);
        chk("R10", "stray write ignored", rsp_rdata, 8'hFF);

        // R5 load works again after unlock
        issue(3'd5, 4'h0, 8'h96);
        chk("R5", "load after wipe", preg_q, 8'h96);

        finish_run();
    end

endmodule